// File: doc/BRIEF.md
# Serial Control Word Receiver

This block receives 12-bit control words over a three-wire serial link (data, shift clock, latch strobe) and holds them in two parallel destination registers. It belongs to an audio processing device, and all three wires come from a slower external controller. The port listens only while its enable input is high.

A bit is taken on each rising edge of the shift clock and pushed into a 12-bit serial-to-parallel register. The first bit sent arrives first and ends up as the oldest bit. When the strobe rises, the 12 most recent bits are decoded. The oldest bit is the register-select bit. When it is 0, the remaining eleven bits become the attenuation value. When it is 1, the last seven bits become the mode flags.

The three serial inputs and the enable input each pass through a two-stage synchronizer into the system clock domain, and edges are detected there. The outputs are registered, and each destination register has its own one-cycle update pulse.

Top module: `ctl_word_rx`

## Requirements
- R1: Synchronous reset sets `att_o` to 0, `flags_o` to 0 and both update pulses to 0.
- R2: A bit on `sdata_i` is captured only on a rising edge of `sclk_i`. Frame bit B1 is the earliest of the last 12 bits captured and B12 is the latest.
- R3: A rising edge of `strobe_i` with B1 = 0 loads `att_o` with B2..B12. B2 goes to `att_o[10]` (MSB) and B12 goes to `att_o[0]` (LSB).
- R4: A rising edge of `strobe_i` with B1 = 1 loads `flags_o` with B6..B12. The mapping is: `flags_o[6]` = B6 test1, `[5]` = B7 test2, `[4]` = B8 rate, `[3]` = B9 12 dB, `[2]` = B10 sample-rate select 1, `[1]` = B11 sample-rate select 2, `[0]` = B12 de-emphasis. B2..B5 are ignored and `att_o` keeps its value.
- R5: A load with B1 = 0 leaves `flags_o` unchanged.
- R6: If more than 12 bits arrive before the strobe, only the most recent 12 are decoded. If fewer than 12 bits have arrived since reset, the missing older positions read as 0.
- R7: While `en_i` is low, shift-clock and strobe edges have no effect. The bits held in the shift register and both outputs stay unchanged.
- R8: A register changes only when its own update pulse is high. That pulse lasts one cycle and is high in the same cycle the new value appears. This happens three system clock edges after the strobe input rises.
- R9: Falling edges of `sclk_i` and `strobe_i` capture no bit and cause no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Serial interface enable (asynchronous) |
| sdata_i | input | 1 | Serial data (asynchronous) |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| strobe_i | input | 1 | Latch strobe (asynchronous) |
| att_o | output | 11 | Attenuation register |
| flags_o | output | 7 | Mode flag register |
| att_upd_o | output | 1 | One-cycle pulse when `att_o` is written |
| flags_upd_o | output | 1 | One-cycle pulse when `flags_o` is written |

## Verification
The bench sends attenuation words with mixed bits, with all ones and with all zeros. These distinguish MSB-first placement from reversed placement and catch stuck bits. It sends flag words whose ignored bits differ from the flag bits, which shows whether a field is misaligned or the select bit is misrouted. An over-long burst of 17 bits shows whether the decoder uses the newest 12 bits rather than the first 12. Bits and strobes sent with the port disabled, followed by a bare strobe with the port enabled, reveal any shift that leaked through. Outputs and pulses are compared with the model on every clock, so latency and pulse width are checked as well.

// File: rtl/cw_pkg.sv
package cw_pkg;
  localparam int FRAME_W = 12;
  localparam int ATT_W   = FRAME_W - 1;
  localparam int FLAG_W  = 7;
  localparam int SYNC_N  = 2;
endpackage

// File: rtl/cw_sync.sv
module cw_sync #(
  parameter int W      = 4,
  parameter int STAGES = cw_pkg::SYNC_N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= d_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[k] <= '0;
      else     pipe[k] <= pipe[k-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/cw_shifter.sv
module cw_shifter #(
  parameter int W = cw_pkg::FRAME_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] frame_o
);
  logic [W-1:0] frame_q;

  always_ff @(posedge clk) begin
    if (rst)       frame_q <= '0;
    else if (en_i) frame_q <= {frame_q[W-2:0], bit_i};
  end

  assign frame_o = frame_q;

  // R7: without a qualified shift edge, the stored bits hold
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(frame_q));
endmodule

// File: rtl/cw_dest_regs.sv
module cw_dest_regs #(
  parameter int ATT_W  = cw_pkg::ATT_W,
  parameter int FLAG_W = cw_pkg::FLAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              select_i,
  input  logic [ATT_W-1:0]  word_i,
  output logic [ATT_W-1:0]  att_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              att_upd_o,
  output logic              flags_upd_o
);
  logic [ATT_W-1:0]  att_q;
  logic [FLAG_W-1:0] flg_q;
  logic              att_upd_q, flg_upd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      att_q     <= '0;
      flg_q     <= '0;
      att_upd_q <= 1'b0;
      flg_upd_q <= 1'b0;
    end else begin
      att_upd_q <= load_i & ~select_i;
      flg_upd_q <= load_i & select_i;
      if (load_i && !select_i) att_q <= word_i;
      if (load_i &&  select_i) flg_q <= word_i[FLAG_W-1:0];
    end
  end

  assign att_o       = att_q;
  assign flags_o     = flg_q;
  assign att_upd_o   = att_upd_q;
  assign flags_upd_o = flg_upd_q;

  p_att_on_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(att_q) |-> att_upd_q);
  p_flags_on_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(flg_q) |-> flg_upd_q);
  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(att_upd_q && flg_upd_q));
  p_pulse_from_load_r8: assert property (@(posedge clk) disable iff (rst)
    (att_upd_q || flg_upd_q) |-> $past(load_i));
endmodule

// File: rtl/ctl_word_rx.sv
module ctl_word_rx #(
  parameter int FRAME_W = cw_pkg::FRAME_W,
  parameter int FLAG_W  = cw_pkg::FLAG_W,
  parameter int SYNC_N  = cw_pkg::SYNC_N
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_i,
  input  logic                 sdata_i,
  input  logic                 sclk_i,
  input  logic                 strobe_i,
  output logic [FRAME_W-2:0]   att_o,
  output logic [FLAG_W-1:0]    flags_o,
  output logic                 att_upd_o,
  output logic                 flags_upd_o
);
  localparam int ATT_W = FRAME_W - 1;

  // bit order: 0 data, 1 shift clock, 2 strobe, 3 enable
  logic [3:0]         lvl;
  logic [1:0]         prev_q;
  logic               sclk_rise, strb_rise;
  logic [FRAME_W-1:0] frame;

  cw_sync #(.W(4), .STAGES(SYNC_N)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({en_i, strobe_i, sclk_i, sdata_i}),
    .q_o (lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl[2:1];
  end

  assign sclk_rise = lvl[1] & ~prev_q[0] & lvl[3];
  assign strb_rise = lvl[2] & ~prev_q[1] & lvl[3];

  cw_shifter #(.W(FRAME_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .en_i    (sclk_rise),
    .bit_i   (lvl[0]),
    .frame_o (frame)
  );

  cw_dest_regs #(.ATT_W(ATT_W), .FLAG_W(FLAG_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .load_i      (strb_rise),
    .select_i    (frame[FRAME_W-1]),
    .word_i      (frame[ATT_W-1:0]),
    .att_o       (att_o),
    .flags_o     (flags_o),
    .att_upd_o   (att_upd_o),
    .flags_upd_o (flags_upd_o)
  );

  // R9: an edge event lasts a single cycle; a held level is no new edge
  p_sclk_edge_once_r9: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |=> !sclk_rise);
  p_strobe_edge_once_r9: assert property (@(posedge clk) disable iff (rst)
    strb_rise |=> !strb_rise);
endmodule

// File: tb/ctl_word_rx_bench.sv
module ctl_word_rx_bench;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;

  logic        clk = 0, rst = 1;
  logic        en = 0, sdata = 0, sclk = 0, strobe = 0;
  logic [10:0] att;
  logic [6:0]  flags;
  logic        att_upd, flags_upd;

  int    checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";
  bit    q[$];
  logic [10:0] exp_att = 0, pend_att = 0;
  logic [6:0]  exp_flags = 0, pend_flags = 0;
  int    due = -1;
  bit    due_is_flag = 0;

  ctl_word_rx u_ctl_word_rx (
    .clk(clk), .rst(rst), .en_i(en), .sdata_i(sdata), .sclk_i(sclk),
    .strobe_i(strobe), .att_o(att), .flags_o(flags),
    .att_upd_o(att_upd), .flags_upd_o(flags_upd)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", cur_req, what, act, expv, cyc);
    end
  endtask

  // reference comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      bit pa, pf;
      pa = 0; pf = 0;
      if (cyc == due) begin
        if (due_is_flag) begin exp_flags = pend_flags; pf = 1; end
        else             begin exp_att   = pend_att;   pa = 1; end
      end
      check(att == exp_att, "att_o", att, exp_att);
      check(flags == exp_flags, "flags_o", flags, exp_flags);
      check(att_upd == pa, "att_upd_o", att_upd, pa);
      check(flags_upd == pf, "flags_upd_o", flags_upd, pf);
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    sclk = 0; sdata = b;        // sender changes data while clock is low
    wait_n(HALF);
    sclk = 1;
    if (en) q.push_back(b);     // R2: capture on rising edge only
    wait_n(HALF);
  endtask

  task automatic send_word(input logic [11:0] w);
    for (int i = 11; i >= 0; i--) send_bit(w[i]);
    sclk = 0;
    wait_n(HALF);
  endtask

  task automatic pulse_strobe();
    logic [11:0] fr;
    wait_n(2);
    strobe = 1;
    if (en) begin
      fr = 0;
      for (int i = 0; i < 12; i++) begin
        int idx;
        idx = q.size() - 12 + i;
        fr = {fr[10:0], (idx >= 0) ? q[idx] : 1'b0};   // R6
      end
      due_is_flag = fr[11];
      pend_att    = fr[10:0];
      pend_flags  = fr[6:0];
      due         = cyc + 3;    // R8 latency
    end
    wait_n(6);
    strobe = 0;                 // R9: falling edge must do nothing
    wait_n(6);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_n(4);
    rst = 0;
    wait_n(1);
    cur_req = "R1";
    check(att == 0 && flags == 0 && !att_upd && !flags_upd, "reset state", {att, flags}, 0);
    en = 1;
    wait_n(6);

    cur_req = "R3";  send_word({1'b0, 11'h5A3}); pulse_strobe();
    cur_req = "R4";  send_word({1'b1, 4'b1010, 7'b1011001}); pulse_strobe();
    cur_req = "R5";  send_word({1'b0, 11'h7FF}); pulse_strobe();
    cur_req = "R4";  send_word({1'b1, 4'b0101, 7'b0100110}); pulse_strobe();
    cur_req = "R2";  send_word({1'b0, 11'h001}); pulse_strobe();
    cur_req = "R3";  send_word({1'b0, 11'h000}); pulse_strobe();

    cur_req = "R6";
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    send_word({1'b0, 11'h2C6}); pulse_strobe();

    cur_req = "R7";
    send_word({1'b1, 4'b0000, 7'b1110000}); // loaded into shifter while enabled
    en = 0; wait_n(6);
    send_word({1'b0, 11'h3FF}); pulse_strobe();
    send_word({1'b1, 11'h7AA}); pulse_strobe();
    en = 1; wait_n(6);
    pulse_strobe();             // must decode the pre-disable word

    cur_req = "R9";
    sclk = 1; wait_n(HALF); sclk = 0; wait_n(HALF);
    if (en) q.push_back(1'b0);  // that one rising edge captured data=0
    pulse_strobe();

    cur_req = "R8"; wait_n(10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule